// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits in front of a shared single-port word memory and serves several requesting cores. Each core can issue a plain load, a plain store, a load-reserved or a store-conditional. A load-reserved returns the addressed word and records, for that core, that the address is being watched. A later store-conditional from the same core writes only if nothing has disturbed that watch. The result is 1 on success and 0 on failure. No lock is ever taken. A core that sees 0 is expected to run its read-compute-store sequence again.

Success depends only on whether another core wrote the watched address in between. It does not depend on the data value. One request is granted per cycle by fixed priority, and the lowest core index wins. The reservation check and the write it controls therefore happen in that one granted cycle. A request is held by the core until its grant bit is seen high. Every request gets exactly one response one cycle later. The response is tagged with the requester's index.

Top module: `rsvmon_top`

## Requirements
- R1: After reset no response is pending and no core holds a reservation, so a store-conditional issued before any load-reserved returns 0 and does not write.
- R2: At most one grant per cycle, only to a requesting core; core 0 has the highest priority, then 1, then 2; any pending request gets a grant in that cycle.
- R3: Each grant produces exactly one response in the next cycle, whose ID field equals the granted core's index.
- R4: Operation encoding per core: 2'b00 load, 2'b01 store, 2'b10 load-reserved, 2'b11 store-conditional; a load or load-reserved returns the word stored at the address.
- R5: A load-reserved records its address for the issuing core; a newer load-reserved of the same core replaces the older one.
- R6: A store-conditional whose core holds a reservation on the same address writes its data and returns 1.
- R7: A store-conditional to an address other than its core's reserved one returns 0 and leaves memory unchanged.
- R8: A store-conditional clears its core's reservation whether it passes or fails, so a second one right after fails.
- R9: A plain store clears the reservations of other cores on that address only; reservations on other addresses, and the storing core's own reservation, survive.
- R10: A successful store-conditional clears every other core's reservation on the same address.
- R11: A plain store writes its data unconditionally and its response data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CORES | Request pending, one bit per core |
| reqOp | input | 2*NUM_CORES | Operation code per core, core i at bits [2i+1:2i] |
| reqAddr | input | NUM_CORES*ADDR_W | Word address per core |
| reqWdata | input | NUM_CORES*DATA_W | Store data per core |
| reqGrant | output | NUM_CORES | One-hot grant for the current cycle |
| rspValid | output | 1 | Response present |
| rspId | output | IDX_W | Index of the core the response belongs to |
| rspData | output | DATA_W | Read word, or 1/0 flag for store-conditional, or 0 for store |

## Verification
A plain store from one core and a store-conditional from another core can reach the monitor in the same cycle. The same holds for a successful store-conditional and another core's store. Both cases are provoked by raising the two requests on the same clock edge, once in each index order. The arbitration order then decides whether the store breaks the reservation before the conditional is judged. The bench predicts the response order and flags from priority alone. It then confirms the final memory word with a follow-up load.

// File: rtl/rsvmon_pkg.sv
package rsvmon_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LR    = 2'b10,
    OP_SC    = 2'b11
  } memOp_t;

  // strobes from control to datapath for the granted request
  typedef struct packed {
    logic memWrite;   // commit write data to memory
    logic rspFire;    // capture a response
    logic rspUseMem;  // response carries the memory word
    logic rspFlag;    // flag value when the word is not used
  } strobe_t;

endpackage

// File: rtl/rsvmon_arbiter.sv
module rsvmon_arbiter #(
  parameter int NUM_CORES = 3,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_CORES-1:0] reqValid,
  output logic [NUM_CORES-1:0] grant,
  output logic [IDX_W-1:0]     grantIdx,
  output logic                 anyGrant
);

  // fixed priority: lowest index wins
  always_comb begin
    grant    = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        grantIdx = IDX_W'(i);
        anyGrant = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rsvmon_ctrl.sv
module rsvmon_ctrl
  import rsvmon_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 4,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyGrant,
  input  logic [IDX_W-1:0]  grantIdx,
  input  memOp_t            grantOp,
  input  logic [ADDR_W-1:0] grantAddr,
  output strobe_t           strobe
);

  logic              resValid [NUM_CORES];
  logic [ADDR_W-1:0] resAddr  [NUM_CORES];
  logic              scHit;
  logic              isStore;
  logic              isSc;
  logic              isLr;

  assign isStore = anyGrant && (grantOp == OP_STORE);
  assign isSc    = anyGrant && (grantOp == OP_SC);
  assign isLr    = anyGrant && (grantOp == OP_LR);

  // reservation lookup for the granted core
  always_comb begin
    scHit = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (grantIdx == IDX_W'(i) && resValid[i] && resAddr[i] == grantAddr)
        scHit = 1'b1;
    end
  end

  // per-core reservation registers
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_res
    logic mine;
    logic match;
    logic breakOther;
    assign mine       = anyGrant && (grantIdx == IDX_W'(g));
    assign match      = resValid[g] && (resAddr[g] == grantAddr);
    assign breakOther = !mine && match && (isStore || (isSc && scHit));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resValid[g] <= 1'b0;
        resAddr[g]  <= '0;
      end else if (mine && isLr) begin
        resValid[g] <= 1'b1;
        resAddr[g]  <= grantAddr;
      end else if (mine && isSc) begin
        resValid[g] <= 1'b0;
      end else if (breakOther) begin
        resValid[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.memWrite  = isStore || (isSc && scHit);
    strobe.rspFire   = anyGrant;
    strobe.rspUseMem = (grantOp == OP_LOAD) || (grantOp == OP_LR);
    strobe.rspFlag   = isSc && scHit;
  end

endmodule

// File: rtl/rsvmon_dp.sv
module rsvmon_dp
  import rsvmon_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  grantIdx,
  input  logic [ADDR_W-1:0] grantAddr,
  input  logic [DATA_W-1:0] grantWdata,
  output logic              rspValid,
  output logic [IDX_W-1:0]  rspId,
  output logic [DATA_W-1:0] rspData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;

  assign rdWord = mem[grantAddr];

  always_ff @(posedge clk) begin
    if (strobe.memWrite) mem[grantAddr] <= grantWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspId    <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.rspFire;
      if (strobe.rspFire) begin
        rspId   <= grantIdx;
        rspData <= strobe.rspUseMem ? rdWord : {{(DATA_W-1){1'b0}}, strobe.rspFlag};
      end
    end
  end

endmodule

// File: rtl/rsvmon_top.sv
module rsvmon_top
  import rsvmon_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [2*NUM_CORES-1:0]      reqOp,
  input  logic [NUM_CORES*ADDR_W-1:0] reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0] reqWdata,
  output logic [NUM_CORES-1:0]        reqGrant,
  output logic                        rspValid,
  output logic [IDX_W-1:0]            rspId,
  output logic [DATA_W-1:0]           rspData
);

  logic [IDX_W-1:0]  grantIdx;
  logic              anyGrant;
  memOp_t            selOp;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selWdata;
  strobe_t           strobe;

  rsvmon_arbiter #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) arb_i (
    .reqValid(reqValid),
    .grant   (reqGrant),
    .grantIdx(grantIdx),
    .anyGrant(anyGrant)
  );

  always_comb begin
    selOp    = OP_LOAD;
    selAddr  = '0;
    selWdata = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (grantIdx == IDX_W'(i)) begin
        selOp    = memOp_t'(reqOp[2*i +: 2]);
        selAddr  = reqAddr[ADDR_W*i +: ADDR_W];
        selWdata = reqWdata[DATA_W*i +: DATA_W];
      end
    end
  end

  rsvmon_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .anyGrant (anyGrant),
    .grantIdx (grantIdx),
    .grantOp  (selOp),
    .grantAddr(selAddr),
    .strobe   (strobe)
  );

  rsvmon_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .grantIdx  (grantIdx),
    .grantAddr (selAddr),
    .grantWdata(selWdata),
    .rspValid  (rspValid),
    .rspId     (rspId),
    .rspData   (rspData)
  );

endmodule

// File: rtl/rsvmon_checker.sv
module rsvmon_checker #(
  parameter int NUM_CORES = 3,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] reqValid,
  input logic [NUM_CORES-1:0] reqGrant,
  input logic [1:0]           grantOp,
  input logic                 rspValid,
  input logic [IDX_W-1:0]     rspId,
  input logic [DATA_W-1:0]    rspData
);

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant));

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  p_core0_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> reqGrant[0]);

  p_pending_served_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> (|reqGrant));

  p_rsp_follows_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|reqGrant) |=> rspValid);

  p_no_spurious_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(|reqGrant) |=> !rspValid);

  p_rsp_id_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqGrant) == (NUM_CORES'(1) << rspId));

  p_sc_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((|reqGrant) && grantOp == 2'b11) |=> rspData <= DATA_W'(1));

  p_store_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((|reqGrant) && grantOp == 2'b01) |=> rspData == '0);

endmodule

bind rsvmon_top rsvmon_checker #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqGrant(reqGrant),
  .grantOp (selOp),
  .rspValid(rspValid),
  .rspId   (rspId),
  .rspData (rspData)
);

// File: tb/rsvmon_tb.sv
module rsvmon_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  localparam logic [1:0] LD = 2'b00;
  localparam logic [1:0] ST = 2'b01;
  localparam logic [1:0] LR = 2'b10;
  localparam logic [1:0] SC = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    reqValid;
  logic [2*NC-1:0]  reqOp;
  logic [NC*AW-1:0] reqAddr;
  logic [NC*DW-1:0] reqWdata;
  logic [NC-1:0]    reqGrant;
  logic             rspValid;
  logic [IW-1:0]    rspId;
  logic [DW-1:0]    rspData;

  logic          vValid [NC];
  logic [1:0]    vOp    [NC];
  logic [AW-1:0] vAddr  [NC];
  logic [DW-1:0] vData  [NC];

  typedef struct {
    int           id;
    logic [DW-1:0] data;
    string        tag;
  } item_t;

  item_t sbQ[$];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      reqValid[i]            = vValid[i];
      reqOp[2*i +: 2]        = vOp[i];
      reqAddr[AW*i +: AW]    = vAddr[i];
      reqWdata[DW*i +: DW]   = vData[i];
    end
  end

  rsvmon_top #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqGrant(reqGrant),
    .rspValid(rspValid), .rspId(rspId), .rspData(rspData)
  );

  task automatic expectRsp(int id, logic [DW-1:0] d, string tag);
    item_t it;
    it.id = id; it.data = d; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // drive one request and hold it until its grant is seen
  task automatic issue(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    bit done = 0;
    @(negedge clk);
    vOp[c] = op; vAddr[c] = a; vData[c] = d; vValid[c] = 1'b1;
    while (!done) begin
      #(CLK_PERIOD/4);
      if (reqGrant[c]) done = 1;
      @(negedge clk);
    end
    vValid[c] = 1'b0;
  endtask

  task automatic req(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic [DW-1:0] exp, string tag);
    expectRsp(c, exp, tag);
    issue(c, op, a, d);
  endtask

  task automatic drain();
    int n = 0;
    while (sbQ.size() != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    checks++;
    if (sbQ.size() != 0) begin
      fails++;
      $display("FAIL R3 missing responses actual=%0d expected=0", sbQ.size());
      sbQ.delete();
    end
  endtask

  // monitor: compare each response with the scoreboard head
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (sbQ.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected response actual id=%0d data=%h expected none",
                 rspId, rspData);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        if (int'(rspId) != it.id || rspData !== it.data) begin
          fails++;
          $display("FAIL %s actual id=%0d data=%h expected id=%0d data=%h",
                   it.tag, rspId, rspData, it.id, it.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      vValid[i] = 1'b0; vOp[i] = LD; vAddr[i] = '0; vData[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      fails++; $display("FAIL R1 rspValid after reset actual=%b expected=0", rspValid);
    end
    checks++;
    if (reqGrant !== '0) begin
      fails++; $display("FAIL R2 grant with no request actual=%b expected=000", reqGrant);
    end

    // seed memory with plain stores (R11)
    req(0, ST, 4'd3, 16'h1111, 16'h0000, "R11 store response");
    req(0, ST, 4'd5, 16'h2222, 16'h0000, "R11 store response");

    // no reservation since reset (R1)
    req(1, SC, 4'd3, 16'hAAAA, 16'h0000, "R1 sc without reservation");
    req(1, LD, 4'd3, 16'h0000, 16'h1111, "R1 memory untouched by failed sc");

    // basic pass (R4, R5, R6)
    req(1, LR, 4'd3, 16'h0000, 16'h1111, "R4 lr returns word");
    req(1, SC, 4'd3, 16'h3333, 16'h0001, "R6 sc passes");
    req(2, LD, 4'd3, 16'h0000, 16'h3333, "R6 sc wrote data");

    // consumed (R8)
    req(1, SC, 4'd3, 16'h4444, 16'h0000, "R8 second sc fails");
    req(1, LD, 4'd3, 16'h0000, 16'h3333, "R8 memory unchanged");

    // address mismatch (R7)
    req(1, LR, 4'd3, 16'h0000, 16'h3333, "R4 lr returns word");
    req(1, SC, 4'd5, 16'h5555, 16'h0000, "R7 sc wrong address fails");
    req(1, LD, 4'd5, 16'h0000, 16'h2222, "R7 memory unchanged");

    // newer lr replaces older (R5)
    req(1, LR, 4'd3, 16'h0000, 16'h3333, "R5 first lr");
    req(1, LR, 4'd5, 16'h0000, 16'h2222, "R5 second lr");
    req(1, SC, 4'd3, 16'h6666, 16'h0000, "R5 old reservation replaced");
    req(1, LD, 4'd3, 16'h0000, 16'h3333, "R5 memory unchanged");

    // other core store breaks reservation (R9)
    req(2, LR, 4'd5, 16'h0000, 16'h2222, "R9 lr");
    req(0, ST, 4'd5, 16'h7777, 16'h0000, "R9 store by other core");
    req(2, SC, 4'd5, 16'h8888, 16'h0000, "R9 broken reservation fails");
    req(2, LD, 4'd5, 16'h0000, 16'h7777, "R9 store data kept");

    // store elsewhere does not break (R9)
    req(2, LR, 4'd5, 16'h0000, 16'h7777, "R9 lr");
    req(0, ST, 4'd3, 16'h9999, 16'h0000, "R9 store to other address");
    req(2, SC, 4'd5, 16'h0808, 16'h0001, "R9 unrelated store keeps reservation");
    req(2, LD, 4'd5, 16'h0000, 16'h0808, "R9 sc data written");

    // own store does not break (R9)
    req(2, LR, 4'd3, 16'h0000, 16'h9999, "R9 lr");
    req(2, ST, 4'd3, 16'h1234, 16'h0000, "R9 own store");
    req(2, SC, 4'd3, 16'h4321, 16'h0001, "R9 own store keeps reservation");
    req(2, LD, 4'd3, 16'h0000, 16'h4321, "R9 sc data written");

    // successful sc clears other reservation (R10)
    req(0, LR, 4'd5, 16'h0000, 16'h0808, "R10 lr core0");
    req(1, LR, 4'd5, 16'h0000, 16'h0808, "R10 lr core1");
    req(0, SC, 4'd5, 16'h0A0A, 16'h0001, "R10 first sc passes");
    req(1, SC, 4'd5, 16'h0B0B, 16'h0000, "R10 second core sc fails");
    req(1, LD, 4'd5, 16'h0000, 16'h0A0A, "R10 memory holds winner");

    // same cycle: store (core0) beats sc (core1) (R2, R9)
    req(1, LR, 4'd3, 16'h0000, 16'h4321, "R5 lr");
    expectRsp(0, 16'h0000, "R2 store granted first");
    expectRsp(1, 16'h0000, "R9 sc after same-cycle store fails");
    fork
      issue(0, ST, 4'd3, 16'hCCCC);
      issue(1, SC, 4'd3, 16'hDDDD);
    join
    req(2, LD, 4'd3, 16'h0000, 16'hCCCC, "R9 store data kept");

    // same cycle: sc (core0) beats store (core1) (R2, R6)
    req(0, LR, 4'd3, 16'h0000, 16'hCCCC, "R5 lr");
    expectRsp(0, 16'h0001, "R6 sc granted first passes");
    expectRsp(1, 16'h0000, "R11 store response");
    fork
      issue(0, SC, 4'd3, 16'hEEEE);
      issue(1, ST, 4'd3, 16'hFFFF);
    join
    req(2, LD, 4'd3, 16'h0000, 16'hFFFF, "R11 later store overwrites");

    // three simultaneous loads: priority order (R2)
    expectRsp(0, 16'h0A0A, "R2 core0 first");
    expectRsp(1, 16'h0A0A, "R2 core1 second");
    expectRsp(2, 16'h0A0A, "R2 core2 third");
    fork
      issue(2, LD, 4'd5, 16'h0000);
      issue(1, LD, 4'd5, 16'h0000);
      issue(0, LD, 4'd5, 16'h0000);
    join

    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule